// File: doc/BRIEF.md
# Floppy DMA Register File

This block is the processor-facing register set of a floppy-disk DMA channel. The processor addresses it by word, and only the low three bits of the word address matter. Behind those addresses sit four things: a 16-bit control word, a 24-bit transfer address, a byte counter and a sticky error flag.

One data slot is shared between two uses, and control bits choose which. It either loads the counter from a sector count or passes a byte through to one of four floppy-controller registers. The counter holds bytes but reads back as sectors, rounded up.

The transfer engine receives the control word, the counter and the address. It drives strobes back to decrement the counter, step the address by two and flag an error. Changing the transfer direction clears the channel state. A one-cycle pulse tells the engine to drop its own buffer state at the same moment.

Top module: `disk_dma_regs`

## Requirements
- R1: After the active-low asynchronous reset, the control word, byte counter, address and error flag are zero. Slot 3 then reads 0xFFF9 while the floppy DRQ input is low.
- R2: Only `cpu_addr_i[2:0]` selects a slot, so address 0xB behaves as slot 3. Slots 0, 1 and 7 read 0xFFFF, and writes to them change no state.
- R3: With control bit 4 set, a write to slot 2 loads the counter with `wdata[7:0]` × 512. A read of slot 2 returns (counter + 511) >> 9, zero-extended.
- R4: With control bits 4 and 3 both clear, slot 2 reaches the floppy register that control bits 2:1 select. A read raises `fdc_rd_o` and returns {0xFF, `fdc_rdata_i`}. A write raises `fdc_we_o` and puts `wdata[7:0]` on `fdc_wdata_o`.
- R5: With bit 4 clear and bit 3 set, slot 2 reads 0xFFFF. A write there leaves the counter unchanged and raises no floppy strobe.
- R6: Slot 3 reads 0xFFF8 with three flags ORed in: bit 0 = no error, bit 1 = counter nonzero, bit 2 = `fdc_drq_i`.
- R7: A slot 3 write stores the full control word. If bit 8 (direction) changes, the same edge clears the counter and the error flag, and `state_clr_o` is high during that write cycle. Otherwise `state_clr_o` stays low.
- R8: Slots 4, 5 and 6 write address bits 23:16, 15:8 and 7:0. A slot 6 write forces bit 0 to zero. Reads return 0xFF00 ORed with the matching byte.
- R9: `cnt_dec_i` lowers a nonzero counter by one and leaves zero at zero. A counter load or clear in the same cycle takes precedence.
- R10: `addr_inc_i` adds 2 to the address, wrapping at 24 bits. A processor write to any address byte in the same cycle takes precedence.
- R11: `err_set_i` sets the error flag, which stays set through control writes that keep the direction and clears only on a direction change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_sel_i | input | 1 | Processor access strobe |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address; low 3 bits decoded |
| cpu_wdata_i | input | 16 | Write data |
| cpu_rdata_o | output | 16 | Read data for the addressed slot (combinational) |
| fdc_sel_o | output | 2 | Floppy register select |
| fdc_rd_o | output | 1 | Floppy register read strobe |
| fdc_we_o | output | 1 | Floppy register write strobe |
| fdc_wdata_o | output | 8 | Floppy register write data |
| fdc_rdata_i | input | 8 | Floppy register read data |
| fdc_drq_i | input | 1 | Floppy data request |
| ctrl_o | output | 16 | Control word |
| byte_cnt_o | output | CNT_W | Remaining byte count |
| dma_addr_o | output | DMA_AW | Transfer address |
| cnt_dec_i | input | 1 | Decrement counter |
| addr_inc_i | input | 1 | Advance address by 2 |
| err_set_i | input | 1 | Set the error flag |
| state_clr_o | output | 1 | Engine state clear pulse |

## Verification
The bench goes after the places where a design is most likely to go wrong:
- **Sector rounding.** A count of one byte must read as one sector. Truncating instead would read 0, and a count of 1535 bytes would read 2 instead of 3.
- **Counter limits.** Decrementing at zero must hold at zero; a design that wraps would jump to 0x1FFFF. A load in the same cycle as a decrement must win, or the loaded count comes back one short.
- **Address limits.** The address must wrap from 0xFFFFFE to 0. An odd low-byte write must be forced even. An address write must take priority over a simultaneous increment.
- **Direction handling.** Rewriting the control word with the same direction must keep the error flag and the counter. Flipping the direction must clear both and pulse the engine. A design keyed on any control change would wipe a live count.
- **Slot steering.** The shared slot must open the floppy port only when both selector bits are clear. Aliased addresses must decode to the same slot.

// File: rtl/disk_dma_pkg.sv
package disk_dma_pkg;
  localparam int SLOT_W = 3;
  localparam logic [SLOT_W-1:0] SLOT_DATA   = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_STATUS = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_AHI    = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_AMID   = 3'd5;
  localparam logic [SLOT_W-1:0] SLOT_ALO    = 3'd6;

  localparam int CB_FSEL_LO = 1;
  localparam int CB_HDSEL   = 3;
  localparam int CB_CNTSEL  = 4;
  localparam int CB_DRQSRC  = 7;
  localparam int CB_DIR     = 8;

  localparam int DATA_W    = 16;
  localparam int SEC_W     = 8;
  localparam int SEC_SHIFT = 9;
endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import disk_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              err_set_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              err_o,
  output logic              dir_flip_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic              err_q;

  assign dir_flip_o = wr_i && (wdata_i[CB_DIR] != ctrl_q[CB_DIR]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_i) ctrl_q <= wdata_i;
      if (dir_flip_o)     err_q <= 1'b0;
      else if (err_set_i) err_q <= 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;
  assign err_o  = err_q;
endmodule

// File: rtl/dma_count_reg.sv
module dma_count_reg #(
  parameter int SEC_W     = 8,
  parameter int SEC_SHIFT = 9,
  localparam int CNT_W    = SEC_W + SEC_SHIFT,
  localparam int RND_W    = CNT_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   load_i,
  input  logic [SEC_W-1:0]       load_sec_i,
  input  logic                   dec_i,
  output logic [CNT_W-1:0]       cnt_o,
  output logic [RND_W-SEC_SHIFT-1:0] sec_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [RND_W-1:0] rnd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (load_i)               cnt_q <= {load_sec_i, {SEC_SHIFT{1'b0}}};
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  // round up to whole sectors
  assign rnd   = {1'b0, cnt_q} + RND_W'((1 << SEC_SHIFT) - 1);
  assign sec_o = rnd[RND_W-1:SEC_SHIFT];
  assign cnt_o = cnt_q;
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int AW  = 24,
  localparam int NB = AW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] byte_wr_i,
  input  logic [7:0]    wdata_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_inc;
  logic [AW-1:0] addr_d;

  assign addr_inc = addr_q + AW'(2);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] wbyte;
    if (b == 0) begin : g_lo
      assign wbyte = {wdata_i[7:1], 1'b0};
    end else begin : g_hi
      assign wbyte = wdata_i;
    end
    always_comb begin
      if (|byte_wr_i) addr_d[b*8 +: 8] = byte_wr_i[b] ? wbyte : addr_q[b*8 +: 8];
      else if (inc_i) addr_d[b*8 +: 8] = addr_inc[b*8 +: 8];
      else            addr_d[b*8 +: 8] = addr_q[b*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/disk_dma_regs.sv
module disk_dma_regs
  import disk_dma_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DMA_AW = 24,
  localparam int CNT_W = SEC_W + SEC_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_sel_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic [1:0]        fdc_sel_o,
  output logic              fdc_rd_o,
  output logic              fdc_we_o,
  output logic [7:0]        fdc_wdata_o,
  input  logic [7:0]        fdc_rdata_i,
  input  logic              fdc_drq_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic [DMA_AW-1:0] dma_addr_o,
  input  logic              cnt_dec_i,
  input  logic              addr_inc_i,
  input  logic              err_set_i,
  output logic              state_clr_o
);
  localparam int NB    = DMA_AW / 8;
  localparam int SEC_O = CNT_W + 1 - SEC_SHIFT;

  logic [SLOT_W-1:0] slot;
  logic              wr, rd, data_slot, fdc_path;
  logic              err;
  logic [SEC_O-1:0]  sec;
  logic [NB-1:0]     byte_wr;

  assign slot      = cpu_addr_i[SLOT_W-1:0];
  assign wr        = cpu_sel_i && cpu_we_i;
  assign rd        = cpu_sel_i && !cpu_we_i;
  assign data_slot = (slot == SLOT_DATA);
  assign fdc_path  = !ctrl_o[CB_CNTSEL] && !ctrl_o[CB_HDSEL];

  dma_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr && slot == SLOT_STATUS),
    .wdata_i    (cpu_wdata_i),
    .err_set_i  (err_set_i),
    .ctrl_o     (ctrl_o),
    .err_o      (err),
    .dir_flip_o (state_clr_o)
  );

  dma_count_reg #(.SEC_W(SEC_W), .SEC_SHIFT(SEC_SHIFT)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (state_clr_o),
    .load_i     (wr && data_slot && ctrl_o[CB_CNTSEL]),
    .load_sec_i (cpu_wdata_i[SEC_W-1:0]),
    .dec_i      (cnt_dec_i),
    .cnt_o      (byte_cnt_o),
    .sec_o      (sec)
  );

  // slot 4 -> top byte, slot 6 -> bottom byte
  for (genvar b = 0; b < NB; b++) begin : g_bwr
    assign byte_wr[b] = wr && (slot == SLOT_ALO - SLOT_W'(b));
  end

  dma_addr_reg #(.AW(DMA_AW)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_wr_i (byte_wr),
    .wdata_i   (cpu_wdata_i[7:0]),
    .inc_i     (addr_inc_i),
    .addr_o    (dma_addr_o)
  );

  assign fdc_sel_o   = ctrl_o[CB_FSEL_LO +: 2];
  assign fdc_rd_o    = rd && data_slot && fdc_path;
  assign fdc_we_o    = wr && data_slot && fdc_path;
  assign fdc_wdata_o = cpu_wdata_i[7:0];

  always_comb begin
    cpu_rdata_o = '1;
    case (slot)
      SLOT_DATA: begin
        if (ctrl_o[CB_CNTSEL])     cpu_rdata_o = DATA_W'(sec);
        else if (!ctrl_o[CB_HDSEL]) cpu_rdata_o = {8'hFF, fdc_rdata_i};
      end
      SLOT_STATUS: cpu_rdata_o = {13'h1FFF, fdc_drq_i, byte_cnt_o != '0, !err};
      SLOT_AHI:    cpu_rdata_o = {8'hFF, dma_addr_o[23:16]};
      SLOT_AMID:   cpu_rdata_o = {8'hFF, dma_addr_o[15:8]};
      SLOT_ALO:    cpu_rdata_o = {8'hFF, dma_addr_o[7:0]};
      default:     cpu_rdata_o = '1;
    endcase
  end
endmodule

// File: rtl/disk_dma_regs_chk.sv
module disk_dma_regs_chk #(
  parameter int ADDR_W = 4,
  parameter int DMA_AW = 24,
  parameter int CNT_W  = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_sel_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [15:0]       cpu_rdata_o,
  input logic [15:0]       ctrl_o,
  input logic [CNT_W-1:0]  byte_cnt_o,
  input logic [DMA_AW-1:0] dma_addr_o,
  input logic              cnt_dec_i,
  input logic              addr_inc_i,
  input logic              state_clr_o,
  input logic              fdc_rd_o,
  input logic              fdc_we_o
);
  logic [2:0] s;
  logic       wr, cnt_wr, addr_wr;
  assign s       = cpu_addr_i[2:0];
  assign wr      = cpu_sel_i && cpu_we_i;
  assign cnt_wr  = wr && (s == 3'd2 || s == 3'd3);
  assign addr_wr = wr && (s == 3'd4 || s == 3'd5 || s == 3'd6);

  p_reserved_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s == 3'd0 || s == 3'd1 || s == 3'd7) |-> cpu_rdata_o == 16'hFFFF);

  p_fdc_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fdc_rd_o || fdc_we_o) |-> (!ctrl_o[3] && !ctrl_o[4]));

  p_status_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s == 3'd3 |-> cpu_rdata_o[15:3] == 13'h1FFF);

  p_dir_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_clr_o |=> byte_cnt_o == '0);

  p_dec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_dec_i && byte_cnt_o != '0 && !cnt_wr) |=> byte_cnt_o == $past(byte_cnt_o) - 1'b1);

  p_zero_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_cnt_o == '0 && !cnt_wr) |=> byte_cnt_o == '0);

  p_inc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_inc_i && !addr_wr) |=> dma_addr_o == $past(dma_addr_o) + DMA_AW'(2));

  p_addr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_inc_i && !addr_wr) |=> $stable(dma_addr_o));
endmodule

bind disk_dma_regs disk_dma_regs_chk #(.ADDR_W(ADDR_W), .DMA_AW(DMA_AW), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_sel_i   (cpu_sel_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_rdata_o (cpu_rdata_o),
  .ctrl_o      (ctrl_o),
  .byte_cnt_o  (byte_cnt_o),
  .dma_addr_o  (dma_addr_o),
  .cnt_dec_i   (cnt_dec_i),
  .addr_inc_i  (addr_inc_i),
  .state_clr_o (state_clr_o),
  .fdc_rd_o    (fdc_rd_o),
  .fdc_we_o    (fdc_we_o)
);

// File: tb/disk_dma_regs_tb.sv
module disk_dma_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_sel_i = 1'b0, cpu_we_i = 1'b0;
  logic [3:0]  cpu_addr_i = '0;
  logic [15:0] cpu_wdata_i = '0;
  logic [15:0] cpu_rdata_o;
  logic [1:0]  fdc_sel_o;
  logic        fdc_rd_o, fdc_we_o;
  logic [7:0]  fdc_wdata_o;
  logic [7:0]  fdc_rdata_i = '0;
  logic        fdc_drq_i = 1'b0;
  logic [15:0] ctrl_o;
  logic [16:0] byte_cnt_o;
  logic [23:0] dma_addr_o;
  logic        cnt_dec_i = 1'b0, addr_inc_i = 1'b0, err_set_i = 1'b0;
  logic        state_clr_o;

  int vectors = 0, fails = 0;
  bit done = 0;

  // reference state
  int m_ctrl = 0, m_cnt = 0, m_addr = 0, m_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  disk_dma_regs u_dut (.*);

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    int s = int'(cpu_addr_i[2:0]);
    case (s)
      2: if (m_ctrl & 16'h10) return (m_cnt + 511) / 512;
         else if (m_ctrl & 16'h8) return 16'hFFFF;
         else return 16'hFF00 | int'(fdc_rdata_i);
      3: return 16'hFFF8 | (m_err ? 0 : 1) | (m_cnt != 0 ? 2 : 0) | (fdc_drq_i ? 4 : 0);
      4: return 16'hFF00 | ((m_addr >> 16) & 255);
      5: return 16'hFF00 | ((m_addr >> 8) & 255);
      6: return 16'hFF00 | (m_addr & 255);
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic string rtag();
    case (cpu_addr_i[2:0])
      3'd2: return (m_ctrl & 16'h10) ? "R3" : ((m_ctrl & 16'h8) ? "R5" : "R4");
      3'd3: return "R6";
      3'd4, 3'd5, 3'd6: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic compare();
    int s = int'(cpu_addr_i[2:0]);
    bit wr = cpu_sel_i && cpu_we_i;
    bit rd = cpu_sel_i && !cpu_we_i;
    bit fp = ((m_ctrl & 16'h18) == 0) && s == 2;
    chk(rtag(), "rdata", int'(cpu_rdata_o), exp_rdata());
    chk("R7", "ctrl", int'(ctrl_o), m_ctrl);
    chk("R9", "count", int'(byte_cnt_o), m_cnt);
    chk("R10", "addr", int'(dma_addr_o), m_addr);
    chk("R4", "fdc_rd", int'(fdc_rd_o), int'(rd && fp));
    chk("R5", "fdc_we", int'(fdc_we_o), int'(wr && fp));
    chk("R4", "fdc_sel", int'(fdc_sel_o), (m_ctrl >> 1) & 3);
    if (wr && fp) chk("R4", "fdc_wdata", int'(fdc_wdata_o), int'(cpu_wdata_i[7:0]));
    chk("R7", "state_clr", int'(state_clr_o),
        int'(wr && s == 3 && ((int'(cpu_wdata_i) ^ m_ctrl) & 16'h100) != 0));
  endtask

  task automatic model_step();
    int s = int'(cpu_addr_i[2:0]);
    int w = int'(cpu_wdata_i);
    bit wr = cpu_sel_i && cpu_we_i;
    bit flip = wr && s == 3 && ((w ^ m_ctrl) & 16'h100) != 0;
    bit cload = wr && s == 2 && (m_ctrl & 16'h10) != 0;
    bit awr = wr && s >= 4 && s <= 6;
    if (flip) m_cnt = 0;
    else if (cload) m_cnt = (w & 255) * 512;
    else if (cnt_dec_i && m_cnt != 0) m_cnt--;
    if (flip) m_err = 0; else if (err_set_i) m_err = 1;
    if (wr && s == 3) m_ctrl = w;
    if (awr) begin
      if (s == 4) m_addr = (m_addr & 32'h00FFFF) | ((w & 255) << 16);
      if (s == 5) m_addr = (m_addr & 32'hFF00FF) | ((w & 255) << 8);
      if (s == 6) m_addr = (m_addr & 32'hFFFF00) | (w & 254);
    end else if (addr_inc_i) m_addr = (m_addr + 2) & 32'hFFFFFF;
  endtask

  // one clock: drive, compare, advance model
  task automatic cyc(bit sel, bit we, int a, int wd, bit dec = 0, bit inc = 0, bit es = 0);
    cpu_sel_i = sel; cpu_we_i = we; cpu_addr_i = 4'(a); cpu_wdata_i = 16'(wd);
    cnt_dec_i = dec; addr_inc_i = inc; err_set_i = es;
    #1 compare();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
  endtask

  task automatic wr(int a, int d); cyc(1, 1, a, d); endtask
  task automatic rd(int a);        cyc(1, 0, a, 0); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd(3);
    chk("R1", "status after reset", int'(cpu_rdata_o), 16'hFFF9);
    // R2 reserved slots and alias
    rd(0); rd(1); rd(7);
    wr(0, 16'h1234); wr(1, 16'hABCD); wr(7, 16'h5555);
    wr(4'hB, 16'h0010);               // alias of slot 3
    rd(4'hA);
    // R3 sector count rounding
    wr(2, 16'hFF03); rd(2);
    repeat (1) cyc(1, 0, 2, 0, 1);    // 1535 bytes -> still 3 sectors
    rd(2);
    wr(2, 1);
    repeat (511) cyc(0, 0, 3, 0, 1);  // 1 byte left
    rd(2);
    chk("R3", "one byte rounds to one sector", int'(cpu_rdata_o), 1);
    cyc(1, 0, 3, 0, 1);               // reaches zero
    cyc(1, 0, 3, 0, 1);               // R9 hold at zero
    cyc(1, 0, 2, 0, 1);
    cyc(1, 1, 2, 16'h0002, 1);        // R9 load beats decrement
    rd(2);
    // R6 DRQ flag
    fdc_drq_i = 1'b1; rd(3); fdc_drq_i = 1'b0; rd(3);
    // R11 error flag, R7 same-direction rewrite keeps state
    cyc(0, 0, 3, 0, 0, 0, 1);
    rd(3);
    wr(3, 16'h0090); rd(3);
    // R7 direction flip clears
    wr(3, 16'h0190); rd(3); rd(2);
    wr(2, 16'h0004);
    wr(3, 16'h0090); rd(3);
    // R4 floppy port
    wr(3, 16'h0084);
    fdc_rdata_i = 8'h5A; rd(2);
    wr(2, 16'h77C3);
    wr(3, 16'h0086); fdc_rdata_i = 8'hA5; rd(2);
    wr(3, 16'h0080 | 16'h6); rd(2);
    // R5 hard-disk select
    wr(3, 16'h0008); rd(2); wr(2, 16'h0033); rd(3);
    // R8 address bytes
    wr(4, 16'hAB12); wr(5, 16'hCD34); wr(6, 16'hEF57);
    rd(4); rd(5); rd(6);
    chk("R8", "low byte forced even", int'(dma_addr_o), 24'h123456);
    // R10 increment and wrap
    cyc(0, 0, 6, 0, 0, 1); cyc(0, 0, 6, 0, 0, 1); rd(6);
    wr(4, 16'hFF); wr(5, 16'hFF); wr(6, 16'hFE);
    cyc(0, 0, 4, 0, 0, 1); rd(4);
    chk("R10", "wrap to zero", int'(dma_addr_o), 0);
    cyc(1, 1, 5, 16'h0080, 0, 1);     // write beats increment
    rd(5); rd(6);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule